// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block is a one-byte mailbox through which software running on the CPU hands values to an external debugger. When the CPU stores a byte into the mailbox, a dirty flag is raised. The flag stays set until the debugger reads the mailbox from its own port. That port always shows the whole stored byte and the flag beside it. When the CPU reads the mailbox back, it sees the low seven bits of the stored byte, and the flag takes the place of the top bit. Software polls that top bit to learn whether the debugger has collected the previous byte.

The mailbox shares its CPU bus address with an ordinary read/write I/O register. A CPU access at that address reaches the mailbox only when two conditions hold: the debug-enable fuse input is high, and the debugger has turned on mailbox access. Under every other combination, the same reads and writes go to the ordinary register. A parameter can remove the sharing, and then the address always belongs to the mailbox. The default address is I/O location 0x31, which sits at 0x51 in data space.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, the stored mailbox byte, the dirty flag and the ordinary register are all zero: `dbg_data` is 0x00, `dbg_dirty` is 0, and CPU reads at the mailbox address return 0x00.
- R2: A CPU write (`cpu_wr`=1) at `MBOX_ADDR` that is routed to the mailbox stores `cpu_wdata` and sets the dirty flag at the same clock edge. Both are visible on `dbg_data` and `dbg_dirty` after that edge.
- R3: A CPU read (`cpu_rd`=1) at `MBOX_ADDR` that is routed to the mailbox returns, in the same cycle, the current dirty flag on bit 7 and stored bits 6..0 on bits 6..0.
- R4: A debugger read (`dbg_rd`=1) clears the dirty flag at the next edge and leaves the stored byte unchanged.
- R5: When a routed CPU write and a debugger read fall in the same cycle, the new byte is stored and the dirty flag ends up set.
- R6: A routed CPU write while the dirty flag is already set replaces the stored byte, and the flag stays set.
- R7: With sharing enabled, the mailbox is routed only when `fuse_dbg_en`=1 and `dbg_access_en`=1. In the other three combinations, CPU writes at `MBOX_ADDR` leave the stored byte and the dirty flag unchanged.
- R8: An unrouted access at `MBOX_ADDR` uses the ordinary register. A write stores all 8 bits, and a read returns all 8 bits with no flag substitution.
- R9: Accesses at any other address change no state, and reads there return 0x00. A read return is also 0x00 whenever `cpu_rd`=0.
- R10: `dbg_data` always carries the full stored byte, including bit 7, whatever the state of the dirty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU I/O address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data (combinational) |
| fuse_dbg_en | input | 1 | Debug-enable fuse level |
| dbg_access_en | input | 1 | Debugger grants CPU access to the mailbox |
| dbg_rd | input | 1 | Debugger read strobe; clears the dirty flag |
| dbg_data | output | DATA_W | Full stored mailbox byte |
| dbg_dirty | output | 1 | Dirty flag |

## Verification
The bench builds the block with its default values: an 8-bit datapath, a 6-bit address, a mailbox address of 0x31, and address sharing turned on. Because sharing is on, the routing logic and the ordinary register are both present. This lets all four combinations of fuse and debugger enable be driven against a single address, and the ordinary register's full-byte read-back can be set against the mailbox's flag-substituted read-back. Byte values with bit 7 set and with bit 7 clear make the substitution visible in both directions. Accesses at a neighbouring address exercise the decode.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

    // Default geometry of the block
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_ADDR_W    = 6;
    localparam int DEF_MBOX_ADDR = 'h31;

    // Where a CPU access at the decoded address lands
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_MBOX  = 2'd1,
        TGT_PLAIN = 2'd2
    } tgt_e;

    // Per-cycle strobes after decode
    typedef struct packed {
        logic mbox_wr;
        logic mbox_rd;
        logic plain_wr;
        logic plain_rd;
    } strobe_t;

    function automatic strobe_t make_strobes(tgt_e tgt, logic wr, logic rd);
        strobe_t s;
        s.mbox_wr  = wr && (tgt == TGT_MBOX);
        s.mbox_rd  = rd && (tgt == TGT_MBOX);
        s.plain_wr = wr && (tgt == TGT_PLAIN);
        s.plain_rd = rd && (tgt == TGT_PLAIN);
        return s;
    endfunction

endpackage

// File: rtl/dbgmb_route.sv
module dbgmb_route
    import dbgmb_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int MBOX_ADDR = DEF_MBOX_ADDR,
    parameter bit SHARED    = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fuse_en,
    input  logic              acc_en,
    output tgt_e              tgt
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MBOX_ADDR);

    logic hit;
    assign hit = (addr == HIT_ADDR);

    generate
        if (SHARED) begin : g_shared
            always_comb begin
                if (!hit)                  tgt = TGT_NONE;
                else if (fuse_en && acc_en) tgt = TGT_MBOX;
                else                       tgt = TGT_PLAIN;
            end
        end else begin : g_private
            logic unused_en;
            assign unused_en = fuse_en ^ acc_en;
            always_comb tgt = hit ? TGT_MBOX : TGT_NONE;
        end
    endgenerate
endmodule

// File: rtl/dbgmb_store.sv
module dbgmb_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr,
    output logic [DATA_W-1:0] q,
    output logic              dirty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            dirty <= 1'b0;
        end else begin
            if (wr_en) begin
                q     <= wdata;
                dirty <= 1'b1;      // a write outranks a same-cycle clear
            end else if (clr) begin
                dirty <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dbgmb_plain.sv
module dbgmb_plain #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int MBOX_ADDR = DEF_MBOX_ADDR,
    parameter bit SHARED    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              fuse_dbg_en,
    input  logic              dbg_access_en,
    input  logic              dbg_rd,
    output logic [DATA_W-1:0] dbg_data,
    output logic              dbg_dirty
);
    localparam int LOW_W = DATA_W - 1;

    tgt_e              tgt;
    strobe_t           stb;
    logic [DATA_W-1:0] mbox_q;
    logic              mbox_dirty;
    logic [DATA_W-1:0] plain_q;
    logic [DATA_W-1:0] mbox_view;

    dbgmb_route #(
        .ADDR_W    (ADDR_W),
        .MBOX_ADDR (MBOX_ADDR),
        .SHARED    (SHARED)
    ) u_route (
        .addr    (cpu_addr),
        .fuse_en (fuse_dbg_en),
        .acc_en  (dbg_access_en),
        .tgt     (tgt)
    );

    assign stb = make_strobes(tgt, cpu_wr, cpu_rd);

    dbgmb_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (stb.mbox_wr),
        .wdata (cpu_wdata),
        .clr   (dbg_rd),
        .q     (mbox_q),
        .dirty (mbox_dirty)
    );

    generate
        if (SHARED) begin : g_plain
            dbgmb_plain #(.DATA_W(DATA_W)) u_plain (
                .clk   (clk),
                .rst   (rst),
                .wr_en (stb.plain_wr),
                .wdata (cpu_wdata),
                .q     (plain_q)
            );
        end else begin : g_noplain
            assign plain_q = '0;
        end
    endgenerate

    // CPU view: flag on top bit, stored low bits below
    assign mbox_view = {mbox_dirty, mbox_q[LOW_W-1:0]};

    always_comb begin
        unique case (1'b1)
            stb.mbox_rd:  cpu_rdata = mbox_view;
            stb.plain_rd: cpu_rdata = plain_q;
            default:      cpu_rdata = '0;
        endcase
    end

    assign dbg_data  = mbox_q;
    assign dbg_dirty = mbox_dirty;
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int MBOX_ADDR = 'h31,
    parameter bit SHARED    = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              fuse_dbg_en,
    input logic              dbg_access_en,
    input logic              dbg_rd,
    input logic [DATA_W-1:0] dbg_data,
    input logic              dbg_dirty
);
    logic hit, routed;
    assign hit    = (cpu_addr == ADDR_W'(MBOX_ADDR));
    assign routed = hit && (!SHARED || (fuse_dbg_en && dbg_access_en));

    // R2
    wr_sets_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && routed) |=> (dbg_dirty && dbg_data == $past(cpu_wdata)));

    // R4
    dbg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd && !(cpu_wr && routed)) |=> (!dbg_dirty && $stable(dbg_data)));

    // R3
    flag_view_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && routed) |-> (cpu_rdata == {dbg_dirty, dbg_data[DATA_W-2:0]}));

    // R7
    unrouted_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (SHARED && hit && !(fuse_dbg_en && dbg_access_en) && !dbg_rd) |=>
            ($stable(dbg_data) && $stable(dbg_dirty)));

    // R9
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd || !hit) |-> (cpu_rdata == '0));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MBOX_ADDR (MBOX_ADDR),
    .SHARED    (SHARED)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_addr      (cpu_addr),
    .cpu_wr        (cpu_wr),
    .cpu_rd        (cpu_rd),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .fuse_dbg_en   (fuse_dbg_en),
    .dbg_access_en (dbg_access_en),
    .dbg_rd        (dbg_rd),
    .dbg_data      (dbg_data),
    .dbg_dirty     (dbg_dirty)
);

// File: tb/tb_dbg_mailbox.sv
module tb_dbg_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam logic [AW-1:0] MB = 6'h31;
    localparam logic [AW-1:0] OTHER = 6'h30;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] cpu_addr;
    logic          cpu_wr, cpu_rd;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic          fuse_dbg_en, dbg_access_en, dbg_rd;
    logic [DW-1:0] dbg_data;
    logic          dbg_dirty;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_mailbox dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fuse_dbg_en(fuse_dbg_en),
        .dbg_access_en(dbg_access_en), .dbg_rd(dbg_rd), .dbg_data(dbg_data),
        .dbg_dirty(dbg_dirty)
    );

    typedef struct {
        string         req;
        logic [DW-1:0] rdata;
        logic [DW-1:0] data;
        logic          dirty;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // expected state, from the requirements
    logic [DW-1:0] m_mb = '0, m_plain = '0;
    logic          m_dirty = 1'b0;

    task automatic step(input logic [AW-1:0] a, input logic wr, input logic rd,
                        input logic [DW-1:0] wd, input logic drd,
                        input logic fu, input logic en, input string req);
        exp_t e;
        logic routed;
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_rd = rd; cpu_wdata = wd;
        dbg_rd = drd; fuse_dbg_en = fu; dbg_access_en = en;
        routed = (a == MB) && fu && en;
        e.req = req;
        e.data = m_mb;
        e.dirty = m_dirty;
        if (rd && a == MB) e.rdata = routed ? {m_dirty, m_mb[DW-2:0]} : m_plain;
        else               e.rdata = '0;
        exp_q.push_back(e);
        if (wr && routed) begin
            m_mb = wd; m_dirty = 1'b1;
        end else begin
            if (wr && a == MB) m_plain = wd;
            if (drd) m_dirty = 1'b0;
        end
    endtask

    task automatic idle(input string req);
        step(MB, 0, 0, 8'h00, 0, 0, 0, req);
    endtask

    // monitor: compares after the inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (cpu_rdata !== e.rdata || dbg_data !== e.data || dbg_dirty !== e.dirty) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h data=%h dirty=%b, expected rdata=%h data=%h dirty=%b",
                             e.req, cpu_rdata, dbg_data, dbg_dirty, e.rdata, e.data, e.dirty);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cpu_addr = '0; cpu_wr = 0; cpu_rd = 0; cpu_wdata = '0;
        dbg_rd = 0; fuse_dbg_en = 0; dbg_access_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, mailbox view and ordinary view
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R1");
        step(MB, 0, 1, 8'h00, 0, 0, 0, "R1");

        // R2/R3: routed write, flag substituted on bit 7
        step(MB, 1, 0, 8'h3C, 0, 1, 1, "R2");
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R3");   // expect 0xBC
        // R4: debugger read clears flag, data kept
        step(MB, 0, 0, 8'h00, 1, 1, 1, "R4");
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R4");   // expect 0x3C
        // R10/R3: bit 7 of stored byte hidden from CPU once clean
        step(MB, 1, 0, 8'hC3, 0, 1, 1, "R2");
        step(MB, 0, 0, 8'h00, 1, 1, 1, "R10");
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R3");   // expect 0x43, dbg_data C3
        // R6: write while dirty
        step(MB, 1, 0, 8'h11, 0, 1, 1, "R6");
        step(MB, 1, 0, 8'h22, 0, 1, 1, "R6");
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R6");
        // R5: write and debugger read together
        step(MB, 1, 0, 8'h5A, 1, 1, 1, "R5");
        step(MB, 0, 0, 8'h00, 0, 1, 1, "R5");
        // clear before routing tests
        step(MB, 0, 0, 8'h00, 1, 1, 1, "R4");

        // R7/R8: three unrouted combinations hit the ordinary register
        for (int k = 0; k < 3; k++) begin
            logic fu, en;
            fu = k[1]; en = k[0];
            step(MB, 1, 0, 8'h90 + 8'(k), 0, fu, en, "R7");
            step(MB, 0, 1, 8'h00, 0, fu, en, "R8");
        end
        // mailbox untouched, fourth combination routed
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R7");
        step(MB, 1, 1, 8'h7E, 0, 1, 1, "R7");
        step(MB, 0, 1, 8'h00, 0, 0, 1, "R8");   // ordinary still 0x92
        // R7: unrouted write while dirty leaves flag and byte
        step(MB, 1, 0, 8'hEE, 0, 1, 0, "R7");
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R7");

        // R9: other address: no effect, reads zero
        step(OTHER, 1, 0, 8'hFF, 0, 1, 1, "R9");
        step(OTHER, 1, 0, 8'hAA, 0, 0, 0, "R9");
        step(OTHER, 0, 1, 8'h00, 0, 1, 1, "R9");
        step(MB, 0, 1, 8'h00, 0, 1, 1, "R9");
        step(MB, 0, 1, 8'h00, 0, 0, 0, "R9");
        idle("R9");

        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule